// File: doc/BRIEF.md
# Unlock-Sequenced Configuration Port Controller

This block gives a host on a byte-wide I/O bus guarded access to the configuration space of a multi-function peripheral. The configuration space stays hidden until the host writes a fixed key byte twice in a row to an index port. A strap pin, captured during cold reset, chooses one of two base addresses for that port. Once the space is open, a write to the index port picks a configuration register, and the data port, one address above it, reads or writes that register. A key byte written to the index port closes the space again.

Registers come in two groups. Global registers have fixed indices. Per-function registers sit at indices 30h and up, and each logical device has its own copy, chosen through a device-select register. A lock bit in a global control register blocks configuration writes until software clears it. A cold reset restores every register to its default and captures the strap again. A warm reset only closes the configuration space.

Top module: `cfg_unlock_port`

## Requirements
- R1: The strap input is captured while cold reset is asserted. Strap 0 puts the index port at 2Eh and the data port at 2Fh. Strap 1 puts them at 4Eh and 4Fh. The other pair of addresses is ignored. Bit 6 of register 26h reads the captured strap, and writes to that bit have no effect.
- R2: The configuration space opens only after two consecutive writes of 87h to the index port. Any other value written to the index port between the two resets the sequence.
- R3: While the space is open, an index-port write of 02h or of 07h..FFh (other than AAh) loads the index register. Other values leave it unchanged. An index-port read returns the index while the space is open.
- R4: While the space is open, writing AAh to the index port closes it. While the space is closed, reads of both ports return 00h and data-port writes change no register.
- R5: A data-port access reads or writes the register selected by the index. Global registers are stored at 02h, 07h and 20h..2Fh. Every other valid index outside the banked range reads 00h.
- R6: Index 07h is the logical-device select register. Indices 30h..3Fh address a separate bank for each logical device.
- R7: The supported device numbers are 00h..0Bh except 04h. With an unsupported device selected, banked registers read 00h and ignore writes.
- R8: Bit 5 of register 26h is a lock bit. While it is set, data-port writes change no register except that bit itself. The other bits of 26h (except bit 6, see R1) read 0.
- R9: A cold reset closes the space, clears the index and all registers to 00h, and captures the strap again.
- R10: A warm reset closes the configuration space and keeps every register and the index.
- R11: io_rdata is 00h whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous cold reset, active low: clears registers and captures the strap |
| warm_rst_n | input | 1 | Synchronous warm reset, active low: closes the configuration space only |
| strap_alt_base | input | 1 | Base-address strap, captured during cold reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational during io_rd |
| cfg_active | output | 1 | High while the configuration space is open |

## Verification
The assertions check several properties on every cycle:
- the space opens only on a cycle that follows an 87h write to the active index port;
- AAh and a warm reset both close the space;
- a closed space and an idle read strobe both return zero;
- the index and the captured strap hold still when nothing should change them;
- a set lock freezes device select;
- an unsupported device reads zero.

Other behaviours can only be shown by the bench's scenarios:
- that each device keeps its bank apart from the others;
- that an interrupted key sequence has to start over;
- that stored values survive closing the space and a warm reset;
- that a cold reset with the other strap moves the ports and clears the contents.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   typedef enum logic [1:0] {
      ST_LOCKED = 2'd0,
      ST_HALF   = 2'd1,
      ST_OPEN   = 2'd2
   } unlock_st_t;

   localparam logic [7:0] KEY_ENTER = 8'h87;
   localparam logic [7:0] KEY_EXIT  = 8'hAA;
   localparam logic [7:0] IDX_MISC  = 8'h02;
   localparam logic [7:0] IDX_LDEV  = 8'h07;
   localparam logic [7:0] IDX_GCTL  = 8'h26;
   localparam logic [7:0] IDX_BANK0 = 8'h30;
   localparam int         LOCK_BIT  = 5;
   localparam int         STRAP_BIT = 6;

   function automatic logic idx_accepted(input logic [7:0] v);
      return (v == IDX_MISC) || (v >= IDX_LDEV);
   endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int ADDR_W  = 16,
   parameter int BASE_LO = 'h2E,
   parameter int BASE_HI = 'h4E
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              alt_sel,
   output logic              hit_index,
   output logic              hit_data
);
   localparam logic [ADDR_W-1:0] IDX_A0 = ADDR_W'(BASE_LO);
   localparam logic [ADDR_W-1:0] IDX_A1 = ADDR_W'(BASE_HI);
   localparam logic [ADDR_W-1:0] DAT_A0 = ADDR_W'(BASE_LO + 1);
   localparam logic [ADDR_W-1:0] DAT_A1 = ADDR_W'(BASE_HI + 1);

   logic [ADDR_W-1:0] idx_a;
   logic [ADDR_W-1:0] dat_a;

   always_comb begin
      idx_a     = alt_sel ? IDX_A1 : IDX_A0;
      dat_a     = alt_sel ? DAT_A1 : DAT_A0;
      hit_index = (addr == idx_a);
      hit_data  = (addr == dat_a);
   end
endmodule

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
   import cfg_pkg::*;
(
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       warm_rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open_q,
   output logic       idx_load
);
   unlock_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_LOCKED: if (idx_wr && wdata == KEY_ENTER) st_d = ST_HALF;
         ST_HALF:   if (idx_wr) st_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
         ST_OPEN:   if (idx_wr && wdata == KEY_EXIT) st_d = ST_LOCKED;
         default:   st_d = ST_LOCKED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!cold_rst_n || !warm_rst_n) st_q <= ST_LOCKED;
      else                            st_q <= st_d;
   end

   assign open_q   = (st_q == ST_OPEN);
   assign idx_load = open_q && idx_wr && (wdata != KEY_EXIT) && idx_accepted(wdata);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_pkg::*;
#(
   parameter int DEV_N    = 12,
   parameter int SKIP_DEV = 4,
   parameter int BANK_N   = 16,
   parameter int GLOB_LO  = 'h20,
   parameter int GLOB_N   = 16
) (
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       strap_q,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] rd_val,
   output logic [7:0] ldev_q,
   output logic       lock_q
);
   localparam int DSEL_W = (DEV_N > 1) ? $clog2(DEV_N) : 1;
   localparam int DSLOTS = 1 << DSEL_W;
   localparam int BOFF_W = (BANK_N > 1) ? $clog2(BANK_N) : 1;
   localparam int BSLOTS = 1 << BOFF_W;
   localparam int GOFF_W = (GLOB_N > 1) ? $clog2(GLOB_N) : 1;
   localparam int GSLOTS = 1 << GOFF_W;

   generate
      if (GLOB_LO < 8 || GLOB_LO + GLOB_N > int'(IDX_BANK0)) begin : g_bad_glob
         $error("global window must lie in 08h..2Fh");
      end
      if (BANK_N < 1 || int'(IDX_BANK0) + BANK_N > 256) begin : g_bad_bank
         $error("bank window must lie in 30h..FFh");
      end
      if (DEV_N < 1 || DEV_N > 255) begin : g_bad_dev
         $error("DEV_N out of range");
      end
   endgenerate

   logic             wr_ok;
   logic [8:0]       idx9;
   logic             in_bank, in_glob, dev_ok;
   logic [BOFF_W-1:0] boff;
   logic [GOFF_W-1:0] goff;
   logic [7:0]       misc_q;
   logic [7:0]       glob_rd [GSLOTS];
   logic [7:0]       bank_rd [DSLOTS];

   always_comb begin
      idx9    = {1'b0, idx};
      wr_ok   = wr_en && !lock_q;
      in_bank = (idx9 >= 9'(IDX_BANK0)) && (idx9 < 9'(int'(IDX_BANK0) + BANK_N));
      in_glob = (idx9 >= 9'(GLOB_LO)) && (idx9 < 9'(GLOB_LO + GLOB_N));
      boff    = BOFF_W'(idx - IDX_BANK0);
      goff    = GOFF_W'(idx - 8'(GLOB_LO));
      dev_ok  = (ldev_q < 8'(DEV_N)) && (ldev_q != 8'(SKIP_DEV));
   end

   always_ff @(posedge clk) begin
      if (!cold_rst_n) begin
         misc_q <= '0;
         ldev_q <= '0;
         lock_q <= 1'b0;
      end else begin
         if (wr_ok && idx == IDX_MISC) misc_q <= wdata;
         if (wr_ok && idx == IDX_LDEV) ldev_q <= wdata;
         if (wr_en && idx == IDX_GCTL) lock_q <= wdata[LOCK_BIT];
      end
   end

   generate
      for (genvar g = 0; g < GSLOTS; g++) begin : g_glob
         if (g >= GLOB_N) begin : g_none
            assign glob_rd[g] = '0;
         end else if (GLOB_LO + g == int'(IDX_GCTL)) begin : g_ctl
            always_comb begin
               glob_rd[g]            = '0;
               glob_rd[g][STRAP_BIT] = strap_q;
               glob_rd[g][LOCK_BIT]  = lock_q;
            end
         end else begin : g_store
            logic [7:0] val_q;
            always_ff @(posedge clk) begin
               if (!cold_rst_n)                                 val_q <= '0;
               else if (wr_ok && in_glob && goff == GOFF_W'(g)) val_q <= wdata;
            end
            assign glob_rd[g] = val_q;
         end
      end

      for (genvar d = 0; d < DSLOTS; d++) begin : g_dev
         if (d >= DEV_N || d == SKIP_DEV) begin : g_absent
            assign bank_rd[d] = '0;
         end else begin : g_present
            logic [7:0] mem_q [BSLOTS];
            logic       sel;
            assign sel = (ldev_q == 8'(d));
            always_ff @(posedge clk) begin
               if (!cold_rst_n) begin
                  for (int k = 0; k < BSLOTS; k++) mem_q[k] <= '0;
               end else if (wr_ok && in_bank && sel) begin
                  mem_q[boff] <= wdata;
               end
            end
            assign bank_rd[d] = mem_q[boff];
         end
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      if (idx == IDX_MISC)         rd_val = misc_q;
      else if (idx == IDX_LDEV)    rd_val = ldev_q;
      else if (in_glob)            rd_val = glob_rd[goff];
      else if (in_bank && dev_ok)  rd_val = bank_rd[ldev_q[DSEL_W-1:0]];
   end
endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
   import cfg_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BASE_LO  = 'h2E,
   parameter int BASE_HI  = 'h4E,
   parameter int DEV_N    = 12,
   parameter int SKIP_DEV = 4,
   parameter int BANK_N   = 16,
   parameter int GLOB_LO  = 'h20,
   parameter int GLOB_N   = 16
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              strap_alt_base,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   output logic              cfg_active
);
   logic       strap_q;
   logic       hit_index, hit_data;
   logic       idx_load;
   logic [7:0] idx_q;
   logic [7:0] reg_val;
   logic [7:0] ldev_w;
   logic       lock_w;
   logic       data_wr;

   always_ff @(posedge clk) begin
      if (!cold_rst_n) strap_q <= strap_alt_base;
   end

   cfg_port_decode #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
      .addr      (io_addr),
      .alt_sel   (strap_q),
      .hit_index (hit_index),
      .hit_data  (hit_data)
   );

   cfg_unlock_fsm u_fsm (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst_n (warm_rst_n),
      .idx_wr     (io_wr && hit_index),
      .wdata      (io_wdata),
      .open_q     (cfg_active),
      .idx_load   (idx_load)
   );

   always_ff @(posedge clk) begin
      if (!cold_rst_n)   idx_q <= '0;
      else if (idx_load) idx_q <= io_wdata;
   end

   assign data_wr = io_wr && hit_data && cfg_active;

   cfg_reg_bank #(
      .DEV_N(DEV_N), .SKIP_DEV(SKIP_DEV), .BANK_N(BANK_N),
      .GLOB_LO(GLOB_LO), .GLOB_N(GLOB_N)
   ) u_bank (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .strap_q    (strap_q),
      .wr_en      (data_wr),
      .idx        (idx_q),
      .wdata      (io_wdata),
      .rd_val     (reg_val),
      .ldev_q     (ldev_w),
      .lock_q     (lock_w)
   );

   always_comb begin
      io_rdata = '0;
      if (io_rd && cfg_active) begin
         if (hit_index)     io_rdata = idx_q;
         else if (hit_data) io_rdata = reg_val;
      end
   end
endmodule

// File: rtl/cfg_unlock_port_chk.sv
module cfg_unlock_port_chk #(
   parameter int ADDR_W   = 16,
   parameter int BASE_LO  = 'h2E,
   parameter int BASE_HI  = 'h4E,
   parameter int DEV_N    = 12,
   parameter int SKIP_DEV = 4
) (
   input logic              clk,
   input logic              cold_rst_n,
   input logic              warm_rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              cfg_active,
   input logic              strap_q,
   input logic [7:0]        idx_q,
   input logic [7:0]        ldev_w,
   input logic              lock_w
);
   logic [ADDR_W-1:0] en_a, dat_a;
   logic              en_wr, bad_dev;
   assign en_a    = strap_q ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
   assign dat_a   = en_a + ADDR_W'(1);
   assign en_wr   = io_wr && (io_addr == en_a);
   assign bad_dev = (ldev_w >= 8'(DEV_N)) || (ldev_w == 8'(SKIP_DEV));

   a_r1_strap_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
      cold_rst_n |=> $stable(strap_q));
   a_r2_open_after_key: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $rose(cfg_active) |-> $past(en_wr && io_wdata == 8'h87));
   a_r3_index_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !(en_wr && cfg_active) |=> $stable(idx_q));
   a_r4_exit_closes: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (cfg_active && en_wr && io_wdata == 8'hAA) |=> !cfg_active);
   a_r4_closed_reads_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !cfg_active |-> io_rdata == 8'h00);
   a_r7_bad_dev_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (io_rd && cfg_active && io_addr == dat_a && idx_q >= 8'h30 && bad_dev)
         |-> io_rdata == 8'h00);
   a_r8_lock_freezes_ldev: assert property (@(posedge clk) disable iff (!cold_rst_n)
      lock_w |=> $stable(ldev_w));
   a_r10_warm_closes: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !warm_rst_n |=> !cfg_active);
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !io_rd |-> io_rdata == 8'h00);
endmodule

bind cfg_unlock_port cfg_unlock_port_chk #(
   .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
   .DEV_N(DEV_N), .SKIP_DEV(SKIP_DEV)
) u_chk (
   .clk        (clk),
   .cold_rst_n (cold_rst_n),
   .warm_rst_n (warm_rst_n),
   .io_addr    (io_addr),
   .io_wdata   (io_wdata),
   .io_wr      (io_wr),
   .io_rd      (io_rd),
   .io_rdata   (io_rdata),
   .cfg_active (cfg_active),
   .strap_q    (strap_q),
   .idx_q      (idx_q),
   .ldev_w     (ldev_w),
   .lock_w     (lock_w)
);

// File: tb/cfg_unlock_port_tb.sv
module cfg_unlock_port_tb;
   localparam int CLK_P = 10;
   localparam int NV    = 63;

   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0;
   logic        warm_rst_n = 1'b1;
   logic        strap_alt_base = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        cfg_active;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cfg_unlock_port u_dut (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .strap_alt_base(strap_alt_base), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .cfg_active(cfg_active)
   );

   // Vector layout: {is_read, req number, address, write data or expected read}
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 4'd2, 16'h002E, 8'h87},  // R2 first key
      {1'b0, 4'd2, 16'h002E, 8'h87},  // R2 second key opens
      {1'b0, 4'd6, 16'h002E, 8'h07},  // R6 select device register
      {1'b0, 4'd6, 16'h002F, 8'h03},
      {1'b0, 4'd6, 16'h002E, 8'h30},
      {1'b0, 4'd5, 16'h002F, 8'h5A},  // R5 write banked
      {1'b1, 4'd5, 16'h002F, 8'h5A},
      {1'b0, 4'd6, 16'h002E, 8'h07},
      {1'b0, 4'd6, 16'h002F, 8'h01},
      {1'b0, 4'd6, 16'h002E, 8'h30},
      {1'b1, 4'd6, 16'h002F, 8'h00},  // R6 device 1 bank separate
      {1'b0, 4'd6, 16'h002F, 8'hC3},
      {1'b1, 4'd6, 16'h002F, 8'hC3},
      {1'b0, 4'd6, 16'h002E, 8'h07},
      {1'b0, 4'd6, 16'h002F, 8'h03},
      {1'b0, 4'd6, 16'h002E, 8'h30},
      {1'b1, 4'd6, 16'h002F, 8'h5A},  // R6 device 3 kept its value
      {1'b0, 4'd3, 16'h002E, 8'h05},  // R3 invalid index ignored
      {1'b1, 4'd3, 16'h002E, 8'h30},
      {1'b0, 4'd3, 16'h002E, 8'h02},
      {1'b1, 4'd3, 16'h002E, 8'h02},
      {1'b0, 4'd7, 16'h002E, 8'h07},  // R7 skipped device 4
      {1'b0, 4'd7, 16'h002F, 8'h04},
      {1'b0, 4'd7, 16'h002E, 8'h31},
      {1'b0, 4'd7, 16'h002F, 8'h77},
      {1'b1, 4'd7, 16'h002F, 8'h00},
      {1'b0, 4'd7, 16'h002E, 8'h07},  // R7 device 0Ch out of range
      {1'b0, 4'd7, 16'h002F, 8'h0C},
      {1'b0, 4'd7, 16'h002E, 8'h30},
      {1'b1, 4'd7, 16'h002F, 8'h00},
      {1'b0, 4'd5, 16'h002E, 8'h20},  // R5 global register
      {1'b0, 4'd5, 16'h002F, 8'h11},
      {1'b1, 4'd5, 16'h002F, 8'h11},
      {1'b0, 4'd5, 16'h002E, 8'h10},
      {1'b1, 4'd5, 16'h002F, 8'h00},  // R5 unbacked index
      {1'b0, 4'd8, 16'h002E, 8'h26},
      {1'b1, 4'd1, 16'h002F, 8'h00},  // R1 strap 0 in bit 6
      {1'b0, 4'd8, 16'h002F, 8'hFF},
      {1'b1, 4'd8, 16'h002F, 8'h20},  // R8 only lock bit lands
      {1'b0, 4'd8, 16'h002E, 8'h20},
      {1'b0, 4'd8, 16'h002F, 8'h99},
      {1'b1, 4'd8, 16'h002F, 8'h11},  // R8 write blocked
      {1'b0, 4'd8, 16'h002E, 8'h26},
      {1'b0, 4'd8, 16'h002F, 8'h00},
      {1'b1, 4'd8, 16'h002F, 8'h00},  // R8 lock cleared
      {1'b0, 4'd8, 16'h002E, 8'h20},
      {1'b0, 4'd8, 16'h002F, 8'h99},
      {1'b1, 4'd8, 16'h002F, 8'h99},
      {1'b0, 4'd4, 16'h002E, 8'hAA},  // R4 exit
      {1'b1, 4'd4, 16'h002F, 8'h00},
      {1'b1, 4'd4, 16'h002E, 8'h00},
      {1'b0, 4'd4, 16'h002F, 8'h44},  // R4 ignored write
      {1'b0, 4'd2, 16'h002E, 8'h87},
      {1'b0, 4'd2, 16'h002E, 8'h87},
      {1'b1, 4'd3, 16'h002E, 8'h20},  // R3 index retained
      {1'b1, 4'd4, 16'h002F, 8'h99},
      {1'b0, 4'd4, 16'h002E, 8'hAA},
      {1'b0, 4'd2, 16'h002E, 8'h87},  // R2 broken sequence
      {1'b0, 4'd2, 16'h002E, 8'h12},
      {1'b0, 4'd2, 16'h002E, 8'h87},
      {1'b1, 4'd2, 16'h002E, 8'h00},
      {1'b0, 4'd2, 16'h002E, 8'h87},
      {1'b1, 4'd2, 16'h002E, 8'h20}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      check(req, io_rdata, exp);
      io_rd = 1'b0;
   endtask

   task automatic cold(input logic s);
      @(negedge clk);
      strap_alt_base = s; cold_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      cold_rst_n = 1'b1;
   endtask

   initial begin
      cold(1'b0);
      // R9: reset state
      check("R9 active", {7'b0, cfg_active}, 8'h00);
      rd(16'h002E, 8'h00, "R9");
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][28]) rd(VEC[i][23:8], VEC[i][7:0], $sformatf("R%0d vec %0d", VEC[i][27:24], i));
         else            wr(VEC[i][23:8], VEC[i][7:0]);
      end
      // R11: idle strobe reads zero while open with idx 20h
      @(negedge clk); io_addr = 16'h002F; #1;
      check("R11", io_rdata, 8'h00);
      check("R2 open", {7'b0, cfg_active}, 8'h01);
      // R10: warm reset closes, keeps contents
      @(negedge clk); warm_rst_n = 1'b0;
      @(negedge clk); warm_rst_n = 1'b1;
      rd(16'h002E, 8'h00, "R10 closed");
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
      rd(16'h002E, 8'h20, "R10 index kept");
      rd(16'h002F, 8'h99, "R10 data kept");
      // R1 / R9: cold reset with strap 1
      cold(1'b1);
      rd(16'h004E, 8'h00, "R9 closed");
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
      rd(16'h004E, 8'h00, "R1 old port ignored");
      wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
      wr(16'h004E, 8'h26);
      rd(16'h004F, 8'h40, "R1 strap bit");
      rd(16'h002F, 8'h00, "R1 old data port");
      wr(16'h004E, 8'h20);
      rd(16'h004F, 8'h00, "R9 global cleared");
      wr(16'h004E, 8'h07);
      rd(16'h004F, 8'h00, "R9 device select cleared");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule